// File: doc/BRIEF.md
# Multi-Channel Debug Word Bridge

This peripheral moves 32-bit words between a processor and an external debug host. Up to sixteen logical channels share one transmit queue and one receive queue. The processor picks a channel by the address it writes. Each channel has its own transmit data address, and the channel number travels with the word as a 4-bit tag. On the receive side the host supplies a tag with each word. The processor reads the tag of the oldest waiting word from the status register before it pops that word through the receive data address.

On the host side there is one valid/ready word stream for each direction. A single level-sensitive interrupt output is driven by two independent 2-bit condition selectors, one for each queue. The serial debug transport that would feed the host streams is not part of this block.

Top module: `dchan_bridge`

## Requirements
- R1: After reset both queues are empty, the status register reads with TX empty (bit 1) and RX empty (bit 3) set and TX full (bit 0), RX full (bit 2) and both counts clear, both condition selectors are 0, and `irq` is low.
- R2: The configuration register at 0x08 returns the receive depth in bits 7:0 and the transmit depth in bits 15:8, and writes leave those fields unchanged. Bits 17:16 (receive selector) and 19:18 (transmit selector) are writable and read back.
- R3: A write to 0x20 + 8*n (n = 0..15) queues the written word with tag n. The host side presents queued words in write order on `txData`/`txChan` while `txValid` is high, and a word leaves when `txReady` is high at a clock edge.
- R4: A transmit write while the queue is full is dropped. The count stays at the depth and the words already queued come out unchanged and in order.
- R5: Status bits 7:4 give the tag of the word that the next read of 0x18 returns. Reading 0x18 returns that word and removes it.
- R6: Reading 0x18 while the receive queue is empty returns 0 and changes neither the count nor the flags.
- R7: Status holds the TX count in bits 31:24 and the RX count in bits 23:16, along with the four flag bits listed in R1.
- R8: The receive selector values are 0 = never, 1 = queue full, 2 = queue not empty, and 3 = count at or above depth minus depth/4 (12 of 16).
- R9: The transmit selector values are 0 = never, 1 = queue empty, 2 = queue not full, and 3 = count at or below depth/4 (4 of 16).
- R10: `irq` is the OR of the two selected conditions. It stays low when both selectors are 0, whatever the queue states.
- R11: `rxReady` is low while the receive queue is full, and a host word offered then is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register access this cycle |
| regWe | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the same cycle as the access |
| irq | output | 1 | Level interrupt |
| txValid | output | 1 | A transmit word is available to the host |
| txReady | input | 1 | Host takes the transmit word |
| txData | output | 32 | Transmit word |
| txChan | output | 4 | Transmit word tag |
| rxValid | input | 1 | Host offers a receive word |
| rxReady | output | 1 | Receive queue can take a word |
| rxData | input | 32 | Receive word |
| rxChan | input | 4 | Receive word tag |

## Verification
The bench checks the full and empty edges of both queues. A transmit write into a full queue must neither overwrite the oldest entry nor move the count past the depth. A design that wraps its pointers there would hand the host a corrupted order. A receive read of an empty queue must return zero and leave the count alone. A design that pops blindly would underflow the count and report phantom words. The near-full and near-empty thresholds are probed one count on each side of the quarter boundary, which exposes any off-by-one in the comparison. The bench also checks that the reported receive tag advances with each pop, so the tag it reads always belongs to the next word returned.

// File: rtl/dchan_pkg.sv
package dchan_pkg;
  localparam int CHAN_W  = 4;
  localparam int NUM_CHAN = 1 << CHAN_W;

  localparam int OFF_ACCESS = 'h00;
  localparam int OFF_CONFIG = 'h08;
  localparam int OFF_STATUS = 'h10;
  localparam int OFF_RXDATA = 'h18;
  localparam int OFF_TXBASE = 'h20;
  localparam int TX_STRIDE  = 8;

  // Selector encodings (shared by both directions, meaning differs per side)
  localparam logic [1:0] SEL_OFF  = 2'd0;
  localparam logic [1:0] SEL_EDGE = 2'd1;  // rx: full,      tx: empty
  localparam logic [1:0] SEL_ANY  = 2'd2;  // rx: not empty, tx: not full
  localparam logic [1:0] SEL_NEAR = 2'd3;  // rx: near full, tx: near empty

  typedef struct packed {
    logic              txPush;
    logic [CHAN_W-1:0] txTag;
    logic              rxPop;
  } dchanStrobe_t;
endpackage

// File: rtl/dchan_fifo.sv
module dchan_fifo #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CAP);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CAP);

  a_r4_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (count == CAP));

  a_r6_empty_pop_stable: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> (count == '0));

  a_r5_pop_decrements: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/dchan_dpath.sv
module dchan_dpath
  import dchan_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int ENTRY_W  = DATA_W + CHAN_W,
  localparam int TX_CNT_W = $clog2(TX_DEPTH + 1),
  localparam int RX_CNT_W = $clog2(RX_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dchanStrobe_t        strobe,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   rxHeadData,
  output logic [CHAN_W-1:0]   rxHeadTag,
  output logic [TX_CNT_W-1:0] txCount,
  output logic [RX_CNT_W-1:0] rxCount,
  output logic                txFull,
  output logic                txEmpty,
  output logic                rxFull,
  output logic                rxEmpty,
  output logic                txValid,
  input  logic                txReady,
  output logic [DATA_W-1:0]   txData,
  output logic [CHAN_W-1:0]   txChan,
  input  logic                rxValid,
  output logic                rxReady,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [CHAN_W-1:0]   rxChan
);
  logic [ENTRY_W-1:0] txHead, rxHead;

  dchan_fifo #(.WIDTH(ENTRY_W), .DEPTH(TX_DEPTH)) txQueue (
    .clk(clk), .rstN(rstN),
    .push(strobe.txPush), .pop(txReady),
    .wdata({strobe.txTag, busWdata}), .rdata(txHead),
    .count(txCount), .full(txFull), .empty(txEmpty)
  );

  dchan_fifo #(.WIDTH(ENTRY_W), .DEPTH(RX_DEPTH)) rxQueue (
    .clk(clk), .rstN(rstN),
    .push(rxValid), .pop(strobe.rxPop),
    .wdata({rxChan, rxData}), .rdata(rxHead),
    .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  assign txValid    = !txEmpty;
  assign txData     = txHead[DATA_W-1:0];
  assign txChan     = txHead[ENTRY_W-1 -: CHAN_W];
  assign rxReady    = !rxFull;
  assign rxHeadData = rxHead[DATA_W-1:0];
  assign rxHeadTag  = rxHead[ENTRY_W-1 -: CHAN_W];

  a_r11_no_take_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !strobe.rxPop) |=> rxFull && (rxCount == $past(rxCount)));
endmodule

// File: rtl/dchan_ctrl.sv
module dchan_ctrl
  import dchan_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TX_CNT_W = $clog2(TX_DEPTH + 1),
  localparam int RX_CNT_W = $clog2(RX_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regSel,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [3:0]          cfgWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic                irq,
  output dchanStrobe_t        strobe,
  input  logic [DATA_W-1:0]   rxHeadData,
  input  logic [CHAN_W-1:0]   rxHeadTag,
  input  logic [TX_CNT_W-1:0] txCount,
  input  logic [RX_CNT_W-1:0] rxCount,
  input  logic                txFull,
  input  logic                txEmpty,
  input  logic                rxFull,
  input  logic                rxEmpty
);
  localparam logic [ADDR_W-1:0] A_ACCESS = ADDR_W'(OFF_ACCESS);
  localparam logic [ADDR_W-1:0] A_CONFIG = ADDR_W'(OFF_CONFIG);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_RXDATA = ADDR_W'(OFF_RXDATA);
  localparam logic [ADDR_W-1:0] A_TXLO   = ADDR_W'(OFF_TXBASE);
  localparam logic [ADDR_W-1:0] A_TXHI   = ADDR_W'(OFF_TXBASE + TX_STRIDE * NUM_CHAN);
  localparam int STRIDE_SH = $clog2(TX_STRIDE);
  localparam logic [RX_CNT_W-1:0] RX_NEAR = RX_CNT_W'(RX_DEPTH - RX_DEPTH / 4);
  localparam logic [TX_CNT_W-1:0] TX_NEAR = TX_CNT_W'(TX_DEPTH / 4);

  logic [1:0] rxSel, txSel;
  logic isRd, isWr, isTx;
  logic [ADDR_W-1:0] txOffset;
  logic rxCond, txCond;
  logic [31:0] statusWord, configWord;

  assign isRd = regSel && !regWe;
  assign isWr = regSel && regWe;
  assign txOffset = regAddr - A_TXLO;
  assign isTx = (regAddr >= A_TXLO) && (regAddr < A_TXHI)
             && (regAddr[STRIDE_SH-1:0] == '0);

  always_comb begin
    strobe.txPush = isWr && isTx;
    strobe.txTag  = txOffset[STRIDE_SH +: CHAN_W];
    strobe.rxPop  = isRd && (regAddr == A_RXDATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSel <= SEL_OFF;
      txSel <= SEL_OFF;
    end else if (isWr && regAddr == A_CONFIG) begin
      rxSel <= cfgWdata[1:0];
      txSel <= cfgWdata[3:2];
    end
  end

  always_comb begin
    case (rxSel)
      SEL_EDGE: rxCond = rxFull;
      SEL_ANY:  rxCond = !rxEmpty;
      SEL_NEAR: rxCond = (rxCount >= RX_NEAR);
      default:  rxCond = 1'b0;
    endcase
    case (txSel)
      SEL_EDGE: txCond = txEmpty;
      SEL_ANY:  txCond = !txFull;
      SEL_NEAR: txCond = (txCount <= TX_NEAR);
      default:  txCond = 1'b0;
    endcase
  end

  assign irq = rxCond || txCond;

  assign configWord = {12'd0, txSel, rxSel, 8'(TX_DEPTH), 8'(RX_DEPTH)};
  assign statusWord = {8'(txCount), 8'(rxCount), 8'd0, rxHeadTag,
                       rxEmpty, rxFull, txEmpty, txFull};

  always_comb begin
    regRdata = '0;
    if (isRd) begin
      case (regAddr)
        A_ACCESS: regRdata = '0;
        A_CONFIG: regRdata = DATA_W'(configWord);
        A_STATUS: regRdata = DATA_W'(statusWord);
        A_RXDATA: regRdata = rxEmpty ? '0 : rxHeadData;
        default:  regRdata = '0;
      endcase
    end
  end

  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rxSel == SEL_OFF && txSel == SEL_OFF) |-> !irq);

  a_r8_full_raises: assert property (@(posedge clk) disable iff (!rstN)
    (rxSel == SEL_EDGE && rxFull) |-> irq);

  a_r9_empty_raises: assert property (@(posedge clk) disable iff (!rstN)
    (txSel == SEL_EDGE && txEmpty) |-> irq);
endmodule

// File: rtl/dchan_bridge.sv
module dchan_bridge
  import dchan_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  output logic [3:0]        txChan,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [DATA_W-1:0] rxData,
  input  logic [3:0]        rxChan
);
  localparam int TX_CNT_W = $clog2(TX_DEPTH + 1);
  localparam int RX_CNT_W = $clog2(RX_DEPTH + 1);

  dchanStrobe_t        strobe;
  logic [DATA_W-1:0]   rxHeadData;
  logic [CHAN_W-1:0]   rxHeadTag;
  logic [TX_CNT_W-1:0] txCount;
  logic [RX_CNT_W-1:0] rxCount;
  logic txFull, txEmpty, rxFull, rxEmpty;

  dchan_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
               .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) ctrl (
    .clk(clk), .rstN(rstN),
    .regSel(regSel), .regWe(regWe), .regAddr(regAddr),
    .cfgWdata(regWdata[19:16]), .regRdata(regRdata), .irq(irq),
    .strobe(strobe), .rxHeadData(rxHeadData), .rxHeadTag(rxHeadTag),
    .txCount(txCount), .rxCount(rxCount),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty)
  );

  dchan_dpath #(.DATA_W(DATA_W), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(regWdata),
    .rxHeadData(rxHeadData), .rxHeadTag(rxHeadTag),
    .txCount(txCount), .rxCount(rxCount),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txChan(txChan),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData), .rxChan(rxChan)
  );
endmodule

// File: tb/sim_dchan_bridge.sv
module sim_dchan_bridge;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, regWe = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic irq, txValid, rxReady;
  logic txReady = 1'b0, rxValid = 1'b0;
  logic [31:0] txData, rxData = '0;
  logic [3:0] txChan, rxChan = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dchan_bridge u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txChan(txChan),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData), .rxChan(rxChan)
  );

  // {tag, word}
  localparam logic [35:0] VEC [8] = '{
    {4'd0,  32'h0000_0001}, {4'd15, 32'hFFFF_FFFF}, {4'd7, 32'h8080_8000},
    {4'd1,  32'h1234_5678}, {4'd8,  32'h0000_0000}, {4'd3, 32'hA5A5_5A5A},
    {4'd15, 32'h8181_0041}, {4'd2,  32'hDEAD_BEEF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regSel = 1; regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regSel = 0; regWe = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regSel = 1; regWe = 0; regAddr = a;
    #1 d = regRdata;
    @(negedge clk); regSel = 0;
  endtask

  task automatic hostPush(input logic [3:0] c, input logic [31:0] d);
    @(negedge clk); rxValid = 1; rxChan = c; rxData = d;
    @(negedge clk); rxValid = 0;
  endtask

  task automatic hostPop(output logic v, output logic [3:0] c, output logic [31:0] d);
    @(negedge clk); txReady = 1;
    #1 v = txValid; c = txChan; d = txData;
    @(negedge clk); txReady = 0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic v;
    logic [3:0] c;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    busRead(8'h10, r);
    chk("R1 status", r & 32'hFFFF_000F, 32'h0000_000A);
    busRead(8'h08, r);
    chk("R1 config", r, 32'h0000_1010);
    settle(); chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 read-only size fields, writable selectors
    busWrite(8'h08, 32'hFFFF_FFFF);
    busRead(8'h08, r);
    chk("R2 config", r, 32'h000F_1010);
    busWrite(8'h08, 32'h0);
    busRead(8'h08, r);
    chk("R2 config clear", r, 32'h0000_1010);

    // R3 vector table: queued words and tags
    foreach (VEC[i]) busWrite(8'h20 + 8'(8 * VEC[i][35:32]), VEC[i][31:0]);
    busRead(8'h10, r);
    chk("R7 tx count", {24'd0, r[31:24]}, 32'd8);
    chk("R7 tx flags", {28'd0, r[3:0]}, 32'h8);
    foreach (VEC[i]) begin
      hostPop(v, c, r);
      chk("R3 valid", {31'd0, v}, 32'd1);
      chk("R3 tag", {28'd0, c}, {28'd0, VEC[i][35:32]});
      chk("R3 data", r, VEC[i][31:0]);
    end
    settle(); chk("R3 drained", {31'd0, txValid}, 32'd0);

    // R9 transmit selectors and R4 overflow
    busWrite(8'h08, 32'h0004_0000);   // tx: empty
    settle(); chk("R9 empty mode", {31'd0, irq}, 32'd1);
    busWrite(8'h08, 32'h0008_0000);   // tx: not full
    for (int i = 0; i < 16; i++) busWrite(8'h38, 32'h100 + i);
    settle(); chk("R9 not-full at full", {31'd0, irq}, 32'd0);
    busWrite(8'h38, 32'hBAD0_BAD0);
    busRead(8'h10, r);
    chk("R4 count held", {24'd0, r[31:24]}, 32'd16);
    chk("R7 tx full flag", {31'd0, r[0]}, 32'd1);
    busWrite(8'h08, 32'h000C_0000);   // tx: near empty
    for (int i = 0; i < 16; i++) begin
      hostPop(v, c, r);
      chk("R4 order", r, 32'h100 + i);
      chk("R3 tag 3", {28'd0, c}, 32'd3);
      settle();
      if (i == 10) chk("R9 near-empty at 5", {31'd0, irq}, 32'd0);
      if (i == 11) chk("R9 near-empty at 4", {31'd0, irq}, 32'd1);
    end
    settle(); chk("R4 no extra word", {31'd0, txValid}, 32'd0);

    // R10 OR, and quiet when both off
    busWrite(8'h08, 32'h0);
    hostPush(4'd5, 32'h100);
    settle(); chk("R10 both off", {31'd0, irq}, 32'd0);
    busWrite(8'h08, 32'h0004_0000);
    settle(); chk("R10 tx side alone", {31'd0, irq}, 32'd1);

    // R8 receive selectors
    busWrite(8'h08, 32'h0002_0000);   // rx: not empty
    settle(); chk("R8 not-empty", {31'd0, irq}, 32'd1);
    busWrite(8'h08, 32'h0003_0000);   // rx: near full
    for (int i = 1; i < 11; i++) hostPush(4'(i + 5), 32'h100 + i);
    settle(); chk("R8 near-full at 11", {31'd0, irq}, 32'd0);
    hostPush(4'(11 + 5), 32'h100 + 11);
    settle(); chk("R8 near-full at 12", {31'd0, irq}, 32'd1);
    busWrite(8'h08, 32'h0001_0000);   // rx: full
    settle(); chk("R8 full mode at 12", {31'd0, irq}, 32'd0);
    for (int i = 12; i < 16; i++) hostPush(4'(i + 5), 32'h100 + i);
    settle(); chk("R8 full mode at 16", {31'd0, irq}, 32'd1);
    chk("R11 ready low", {31'd0, rxReady}, 32'd0);
    hostPush(4'd0, 32'hBAD0_0000);
    busRead(8'h10, r);
    chk("R11 count held", {24'd0, r[23:16]}, 32'd16);
    chk("R7 rx full flag", {31'd0, r[2]}, 32'd1);
    busWrite(8'h08, 32'h0);

    // R5 drain with tag tracking
    for (int i = 0; i < 16; i++) begin
      busRead(8'h10, r);
      chk("R5 head tag", {28'd0, r[7:4]}, {28'd0, 4'(i + 5)});
      busRead(8'h18, r);
      chk("R5 data", r, 32'h100 + i);
    end

    // R6 empty read
    busRead(8'h18, r);
    chk("R6 empty read", r, 32'd0);
    busRead(8'h10, r);
    chk("R6 status after", r & 32'hFFFF_000F, 32'h0000_000A);
    hostPush(4'd9, 32'h77);
    busRead(8'h18, r);
    chk("R6 next word intact", r, 32'h77);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule